// File: doc/BRIEF.md
# Register Redirection Table

This block sits in the decode stage of a vectorising core. It keeps two 32-entry redirection tables, one for the integer register file and one for the floating-point register file. Each table is indexed by a 5-bit architectural register number. An entry holds a 6-bit physical target, so an instruction can reach any of 64 physical registers. Redirection and vectorisation are independent. An active entry always substitutes its target, and a separate vector flag tells the loop controller to iterate.

Several operand ports look up the tables at the same time, each port with its own file select. A mask marks which ports are sources. The block reduces the source entries to two results: the widest element bit width, and a combined width code. One write port loads entries in either a full 16-bit word or a compact 8-bit word. A compact word always describes a vector entry, and its target is derived from its key.

Top module: `regmap_redirect`

## Requirements
- R1: The integer table (file select 0) and the floating-point table (file select 1) are separate. A write to one leaves every lookup in the other unchanged.
- R2: After reset every entry is inactive. Every lookup then passes its register through, `any_vec_o` is 0, `src_bits_o` is 0 and `src_wcode_o` is 0.
- R3: For an inactive entry, `op_phys_o` equals the register number with a 0 above it, and `op_active_o`, `op_vec_o` and `op_wcode_o` are all 0.
- R4: For an active entry, `op_phys_o` is the stored 6-bit target whether or not the vector flag is set. `op_vec_o` reports the stored vector flag and `op_wcode_o` reports the stored width code.
- R5: A full write (`wr_compact_i`=0) uses this layout: bits 4:0 key, bit 5 file, bits 11:6 target, bits 13:12 width code, bit 14 vector flag, bit 15 active. Writing an entry with active=0 deactivates it.
- R6: A compact write (`wr_compact_i`=1) uses this layout: bits 4:0 key, bit 5 file, bits 7:6 width code. It stores an active vector entry whose target is the key shifted left by two and truncated to 6 bits, so key 17 gives target 4.
- R7: The width codes map to bit widths as follows: 0 is XLEN, 1 is 8, 2 is 16 and 3 is 32. `src_bits_o` is the largest bit width over the ports that are both masked and active, and 0 when there are none.
- R8: `src_wcode_o` combines the codes of the masked, active ports. The result is 0 if any of those codes is 0, and otherwise the largest code. It is 0 when no port qualifies.
- R9: `any_vec_o` is 1 exactly when some lookup port, masked or not, hits an entry that is both active and vector.
- R10: A write becomes visible to lookups only after the next rising clock edge. A later write to the same key and file replaces the earlier entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_compact_i | input | 1 | 1: the write word uses the compact 8-bit layout |
| wr_data_i | input | 16 | Entry word to write |
| op_reg_i | input | NUM_OPS x 5 | Architectural register for each lookup port |
| op_file_i | input | NUM_OPS | Table select per port (0 integer, 1 floating point) |
| src_mask_i | input | NUM_OPS | Ports that are source operands |
| op_phys_o | output | NUM_OPS x 6 | Physical register per port |
| op_vec_o | output | NUM_OPS | Vector flag per port |
| op_active_o | output | NUM_OPS | Entry active per port |
| op_wcode_o | output | NUM_OPS x 2 | Width code per port |
| src_bits_o | output | BITS_W | Widest source element bit width |
| src_wcode_o | output | 2 | Combined source width code |
| any_vec_o | output | 1 | Some looked-up entry is active and vector |

## Verification
The bench first redirects a register that is not a vector. A design that gated the substitution on the vector flag would return the architectural number there. It then writes a compact entry whose shifted key overflows 6 bits, which exposes a target that is wrongly widened or wrongly shifted. The width reduction is tested with a code-0 entry mixed among wider codes: a plain maximum over the codes would give 3 instead of 0. The same test includes an unmasked port and an inactive port, which a reduction that ignored the mask or the active flag would pick up. Finally, a write is checked before and after its clock edge, and a rewrite and a deactivation are applied, to catch write-through lookups and stale entries.

// File: rtl/regmap_pkg.sv
package regmap_pkg;
  localparam int KEY_W    = 5;
  localparam int TGT_W    = KEY_W + 1;
  localparam int NUM_KEYS = 1 << KEY_W;
  localparam int WORD_W   = 16;

  typedef struct packed {
    logic             active;
    logic             isvec;
    logic [1:0]       wcode;
    logic [TGT_W-1:0] target;
  } entry_t;

  function automatic int code_bits(logic [1:0] code, int xlen);
    case (code)
      2'd0:    return xlen;
      2'd1:    return 8;
      2'd2:    return 16;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/regmap_decode.sv
module regmap_decode
  import regmap_pkg::*;
(
  input  logic              compact_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [KEY_W-1:0]  key_o,
  output logic              file_o,
  output entry_t            entry_o
);
  // key and file sit at the same place in both layouts
  assign key_o  = data_i[KEY_W-1:0];
  assign file_o = data_i[KEY_W];

  always_comb begin
    if (compact_i) begin
      entry_o.active = 1'b1;
      entry_o.isvec  = 1'b1;
      entry_o.wcode  = data_i[7:6];
      entry_o.target = TGT_W'({data_i[KEY_W-1:0], 2'b00});
    end else begin
      entry_o.active = data_i[15];
      entry_o.isvec  = data_i[14];
      entry_o.wcode  = data_i[13:12];
      entry_o.target = data_i[11:6];
    end
  end
endmodule

// File: rtl/regmap_table.sv
module regmap_table
  import regmap_pkg::*;
#(
  parameter int NUM_OPS = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [KEY_W-1:0]              wkey_i,
  input  entry_t                        wentry_i,
  input  logic [NUM_OPS-1:0][KEY_W-1:0] rkey_i,
  output entry_t [NUM_OPS-1:0]          rentry_o
);
  entry_t mem_q [NUM_KEYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_KEYS; k++) mem_q[k] <= '0;
    end else if (we_i) begin
      mem_q[wkey_i] <= wentry_i;
    end
  end

  for (genvar p = 0; p < NUM_OPS; p++) begin : g_rd
    assign rentry_o[p] = mem_q[rkey_i[p]];
  end
endmodule

// File: rtl/regmap_width.sv
module regmap_width
  import regmap_pkg::*;
#(
  parameter int NUM_OPS = 4,
  parameter int XLEN    = 64,
  parameter int BITS_W  = $clog2(XLEN + 1)
) (
  input  logic [NUM_OPS-1:0]      sel_i,
  input  logic [NUM_OPS-1:0][1:0] wcode_i,
  output logic [BITS_W-1:0]       bits_o,
  output logic [1:0]              wcode_o
);
  always_comb begin
    int   best;
    logic native_seen;
    logic [1:0] top;
    best        = 0;
    native_seen = 1'b0;
    top         = 2'd0;
    for (int p = 0; p < NUM_OPS; p++) begin
      if (sel_i[p]) begin
        if (code_bits(wcode_i[p], XLEN) > best) best = code_bits(wcode_i[p], XLEN);
        if (wcode_i[p] == 2'd0) native_seen = 1'b1;
        else if (wcode_i[p] > top) top = wcode_i[p];
      end
    end
    bits_o  = BITS_W'(best);
    wcode_o = native_seen ? 2'd0 : top;
  end
endmodule

// File: rtl/regmap_redirect.sv
module regmap_redirect
  import regmap_pkg::*;
#(
  parameter int NUM_OPS = 4,
  parameter int XLEN    = 64,
  parameter int BITS_W  = $clog2(XLEN + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic                          wr_compact_i,
  input  logic [15:0]                   wr_data_i,
  input  logic [NUM_OPS-1:0][4:0]       op_reg_i,
  input  logic [NUM_OPS-1:0]            op_file_i,
  input  logic [NUM_OPS-1:0]            src_mask_i,
  output logic [NUM_OPS-1:0][5:0]       op_phys_o,
  output logic [NUM_OPS-1:0]            op_vec_o,
  output logic [NUM_OPS-1:0]            op_active_o,
  output logic [NUM_OPS-1:0][1:0]       op_wcode_o,
  output logic [BITS_W-1:0]             src_bits_o,
  output logic [1:0]                    src_wcode_o,
  output logic                          any_vec_o
);
  localparam int NUM_FILES = 2;

  logic [KEY_W-1:0] wkey;
  logic             wfile;
  entry_t           wentry;
  entry_t [NUM_OPS-1:0] rd_entry [NUM_FILES];

  regmap_decode u_dec (
    .compact_i (wr_compact_i),
    .data_i    (wr_data_i),
    .key_o     (wkey),
    .file_o    (wfile),
    .entry_o   (wentry)
  );

  for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
    regmap_table #(.NUM_OPS(NUM_OPS)) u_tab (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (wr_en_i && (wfile == f[0])),
      .wkey_i   (wkey),
      .wentry_i (wentry),
      .rkey_i   (op_reg_i),
      .rentry_o (rd_entry[f])
    );
  end

  for (genvar p = 0; p < NUM_OPS; p++) begin : g_op
    entry_t hit;
    assign hit            = op_file_i[p] ? rd_entry[1][p] : rd_entry[0][p];
    assign op_active_o[p] = hit.active;
    assign op_vec_o[p]    = hit.active & hit.isvec;
    assign op_wcode_o[p]  = hit.active ? hit.wcode : 2'd0;
    // redirect regardless of the vector flag
    assign op_phys_o[p]   = hit.active ? hit.target : {1'b0, op_reg_i[p]};
  end

  assign any_vec_o = |op_vec_o;

  regmap_width #(.NUM_OPS(NUM_OPS), .XLEN(XLEN), .BITS_W(BITS_W)) u_width (
    .sel_i   (src_mask_i & op_active_o),
    .wcode_i (op_wcode_o),
    .bits_o  (src_bits_o),
    .wcode_o (src_wcode_o)
  );
endmodule

// File: rtl/regmap_redirect_chk.sv
module regmap_redirect_chk #(
  parameter int NUM_OPS = 4,
  parameter int XLEN    = 64,
  parameter int BITS_W  = $clog2(XLEN + 1)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    wr_en_i,
  input logic                    wr_compact_i,
  input logic [15:0]             wr_data_i,
  input logic [NUM_OPS-1:0][4:0] op_reg_i,
  input logic [NUM_OPS-1:0]      op_file_i,
  input logic [NUM_OPS-1:0]      src_mask_i,
  input logic [NUM_OPS-1:0][5:0] op_phys_o,
  input logic [NUM_OPS-1:0]      op_vec_o,
  input logic [NUM_OPS-1:0]      op_active_o,
  input logic [NUM_OPS-1:0][1:0] op_wcode_o,
  input logic [BITS_W-1:0]       src_bits_o,
  input logic [1:0]              src_wcode_o,
  input logic                    any_vec_o
);
  for (genvar p = 0; p < NUM_OPS; p++) begin : g_p
    a_r3_inactive_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !op_active_o[p] |-> (op_phys_o[p] == {1'b0, op_reg_i[p]} && !op_vec_o[p] && op_wcode_o[p] == 2'd0));
    a_r4_vec_needs_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
      op_vec_o[p] |-> op_active_o[p]);
  end

  a_r9_any_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_vec_o == (|(op_vec_o & op_active_o)));

  a_r7_bits_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_bits_o == 0 || src_bits_o == 8 || src_bits_o == 16 || src_bits_o == 32
     || src_bits_o == BITS_W'(XLEN)));

  a_r7_none_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_mask_i & op_active_o) == '0) |-> (src_bits_o == 0 && src_wcode_o == 2'd0));

  a_r8_native_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_mask_i[0] && op_active_o[0] && op_wcode_o[0] == 2'd0) |-> src_wcode_o == 2'd0);

  a_r6_compact_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_compact_i) |=>
      ((op_reg_i[0] == $past(wr_data_i[4:0]) && op_file_i[0] == $past(wr_data_i[5]))
       -> (op_vec_o[0] && op_phys_o[0] == {$past(wr_data_i[3:0]), 2'b00})));
endmodule

bind regmap_redirect regmap_redirect_chk #(.NUM_OPS(NUM_OPS), .XLEN(XLEN), .BITS_W(BITS_W)) u_chk (.*);

// File: tb/tb_regmap_redirect.sv
module tb_regmap_redirect;
  localparam int NUM_OPS = 4;
  localparam int XLEN    = 64;
  localparam int BITS_W  = $clog2(XLEN + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0, wr_compact = 1'b0;
  logic [15:0] wr_data = '0;
  logic [NUM_OPS-1:0][4:0] op_reg = '0;
  logic [NUM_OPS-1:0] op_file = '0, src_mask = '0;
  logic [NUM_OPS-1:0][5:0] op_phys;
  logic [NUM_OPS-1:0] op_vec, op_active;
  logic [NUM_OPS-1:0][1:0] op_wcode;
  logic [BITS_W-1:0] src_bits;
  logic [1:0] src_wcode;
  logic any_vec;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  regmap_redirect #(.NUM_OPS(NUM_OPS), .XLEN(XLEN)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_compact_i(wr_compact),
    .wr_data_i(wr_data), .op_reg_i(op_reg), .op_file_i(op_file), .src_mask_i(src_mask),
    .op_phys_o(op_phys), .op_vec_o(op_vec), .op_active_o(op_active), .op_wcode_o(op_wcode),
    .src_bits_o(src_bits), .src_wcode_o(src_wcode), .any_vec_o(any_vec)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_op(int p, logic file, logic [4:0] r);
    op_file[p] = file;
    op_reg[p]  = r;
  endtask

  // drive at negedge, hold across one rising edge
  task automatic write_word(logic compact, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_compact = compact; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] full_word(logic act, logic vec, logic [1:0] w,
                                            logic [5:0] tgt, logic file, logic [4:0] key);
    return {act, vec, w, tgt, file, key};
  endfunction

  task automatic t_reset;
    set_op(0, 1'b0, 5'd5); set_op(1, 1'b1, 5'd31);
    src_mask = 4'b1111;
    #2;
    chk("R2", "phys0 after reset", op_phys[0], 5);
    chk("R2", "phys1 after reset", op_phys[1], 31);
    chk("R2", "any_vec after reset", any_vec, 0);
    chk("R2", "src_bits after reset", src_bits, 0);
    chk("R3", "active0 inactive", op_active[0], 0);
  endtask

  task automatic t_scalar_redirect;
    // R5: int key 5 -> target 35, active, not vector, width code 1
    write_word(1'b0, full_word(1'b1, 1'b0, 2'd1, 6'd35, 1'b0, 5'd5));
    set_op(0, 1'b0, 5'd5); set_op(1, 1'b1, 5'd5);
    set_op(2, 1'b0, 5'd0); set_op(3, 1'b0, 5'd0);
    src_mask = 4'b0001;
    #2;
    chk("R4", "scalar redirect phys", op_phys[0], 35);
    chk("R4", "scalar redirect vec", op_vec[0], 0);
    chk("R4", "scalar redirect wcode", op_wcode[0], 1);
    chk("R1", "fp table untouched", op_phys[1], 5);
    chk("R1", "fp active", op_active[1], 0);
    chk("R9", "any_vec scalar only", any_vec, 0);
    chk("R7", "bits code1", src_bits, 8);
  endtask

  task automatic t_compact;
    // R6: fp key 17, width code 2 -> target (17<<2)&63 = 4
    write_word(1'b1, {8'h00, 2'd2, 1'b1, 5'd17});
    set_op(0, 1'b1, 5'd17); set_op(1, 1'b0, 5'd17);
    #2;
    chk("R6", "compact target", op_phys[0], 4);
    chk("R6", "compact vec", op_vec[0], 1);
    chk("R6", "compact wcode", op_wcode[0], 2);
    chk("R1", "int key17 untouched", op_phys[1], 17);
    chk("R9", "any_vec set", any_vec, 1);
  endtask

  task automatic t_widths;
    write_word(1'b0, full_word(1'b1, 1'b1, 2'd3, 6'd6, 1'b0, 5'd6));
    write_word(1'b0, full_word(1'b1, 1'b0, 2'd2, 6'd7, 1'b0, 5'd7));
    write_word(1'b0, full_word(1'b1, 1'b0, 2'd0, 6'd9, 1'b0, 5'd9));
    set_op(0, 1'b0, 5'd5); set_op(1, 1'b0, 5'd6);
    set_op(2, 1'b0, 5'd7); set_op(3, 1'b0, 5'd8);
    src_mask = 4'b1111;
    #2;
    chk("R7", "bits 8/32/16 + inactive", src_bits, 32);
    chk("R8", "code max 3", src_wcode, 3);
    set_op(3, 1'b0, 5'd9);
    #2;
    chk("R7", "bits with native", src_bits, 64);
    chk("R8", "native code dominates", src_wcode, 0);
    src_mask = 4'b0001;
    #2;
    chk("R7", "mask single", src_bits, 8);
    chk("R8", "mask single code", src_wcode, 1);
    chk("R9", "any_vec unmasked port", any_vec, 1);
    src_mask = 4'b1000; set_op(3, 1'b0, 5'd8);
    #2;
    chk("R7", "only inactive masked", src_bits, 0);
    chk("R8", "only inactive code", src_wcode, 0);
  endtask

  task automatic t_timing;
    set_op(0, 1'b0, 5'd6);
    @(negedge clk);
    wr_en = 1'b1; wr_compact = 1'b0;
    wr_data = full_word(1'b1, 1'b1, 2'd3, 6'd40, 1'b0, 5'd6);
    #2;
    chk("R10", "old value before edge", op_phys[0], 6);
    @(negedge clk);
    wr_en = 1'b0;
    #2;
    chk("R10", "rewrite after edge", op_phys[0], 40);
    write_word(1'b0, full_word(1'b0, 1'b0, 2'd0, 6'd0, 1'b0, 5'd5));
    set_op(0, 1'b0, 5'd5);
    #2;
    chk("R5", "deactivated passthru", op_phys[0], 5);
    chk("R3", "deactivated active", op_active[0], 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        t_reset();
        t_scalar_redirect();
        t_compact();
        t_widths();
        t_timing();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule